// File: doc/BRIEF.md
# Fully-Associative Translation Buffer with Address-Space Invalidation

This block caches virtual-to-physical page translations in a small fully-associative table. Each slot holds a virtual page number, an address-space tag, a global flag, a physical frame number and a valid flag. Software-style commands arrive on a single-cycle strobe with a 5-bit opcode. The commands are indexed write, indexed read, associative probe, bulk invalidate by address-space tag, and invalidate-all. Every command is answered by a one-cycle `done` pulse in the cycle after the strobe.

Bulk invalidation selects slots by address-space tag alone and never compares the page number. Slots marked global survive a tag-based invalidation. A write can place a slot directly in the invalid state by raising a kill flag on the entry-high inputs. A 2-bit capability input gates both invalidate commands: below 2 they finish as no-operations.

Top module: `asid_tlb`

## Requirements
- R1: After reset every slot is invalid, and `done` and `err` are low. A read of any slot then returns `rd_valid`=0, and a probe returns `probe_miss`=1.
- R2: Opcode 5'h02 (indexed write) stores `ent_vpn`, `ent_asid`, `ent_global` and `ent_pfn` in slot `cmd_idx`. The slot becomes valid when `ent_kill`=0.
- R3: An indexed write with `ent_kill`=1 stores the fields, but the slot is left invalid.
- R4: Opcode 5'h01 (indexed read) places the stored fields and valid flag of slot `cmd_idx` on the `rd_*` outputs in the `done` cycle. Fields are returned even for an invalid slot.
- R5: Opcode 5'h08 (probe) looks for slots that are valid, whose page number equals `ent_vpn`, and whose tag equals `cur_asid` or whose global flag is 1. `probe_idx` returns the lowest-index such slot with `probe_miss`=0. When no slot qualifies, `probe_miss`=1.
- R6: Opcode 5'h03 (tag invalidate) with `inv_cap`>=2 clears every non-global slot whose tag equals `cur_asid`, whatever its page number. Global slots are unchanged.
- R7: Opcode 5'h04 (invalidate-all) with `inv_cap`>=2 clears every slot, global ones included.
- R8: With `inv_cap` of 0 or 1, opcodes 5'h03 and 5'h04 change no slot. They still raise `done`, with `err`=0.
- R9: Any opcode other than 5'h01, 5'h02, 5'h03, 5'h04 and 5'h08 raises `err` together with `done` and changes no slot. This includes 5'h06.
- R10: `done` is high for exactly the one cycle that follows each strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 5 | Command opcode |
| cmd_idx | input | 4 | Slot index for read and write |
| cur_asid | input | 8 | Current address-space tag |
| inv_cap | input | 2 | Invalidate capability level |
| ent_vpn | input | 19 | Page number to write or probe |
| ent_asid | input | 8 | Tag to write |
| ent_global | input | 1 | Global flag to write |
| ent_pfn | input | 20 | Frame number to write |
| ent_kill | input | 1 | Write the slot as invalid |
| done | output | 1 | Command completion pulse |
| err | output | 1 | Unsupported opcode pulse |
| rd_vpn | output | 19 | Read page number |
| rd_asid | output | 8 | Read tag |
| rd_global | output | 1 | Read global flag |
| rd_pfn | output | 20 | Read frame number |
| rd_valid | output | 1 | Read valid flag |
| probe_idx | output | 4 | Probe hit index |
| probe_miss | output | 1 | Probe found no slot |

## Verification
The hardest state to reach is a table in which a tag invalidate meets every combination at once. That means slots with the current tag, both global and not, slots with other tags, and page numbers repeated across slots so that probe priority matters. The bench fills all sixteen slots from arithmetic patterns that repeat page numbers and cycle through four tags, with every fifth slot global. It then sweeps the current tag and the capability level together, and reads back every slot after each invalidate to compare against its own model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [4:0] {
    OP_READ     = 5'h01,
    OP_WRITE    = 5'h02,
    OP_INV_ASID = 5'h03,
    OP_INV_ALL  = 5'h04,
    OP_RAND_WR  = 5'h06,
    OP_PROBE    = 5'h08
  } tlb_op_e;

  // Bulk invalidates are honoured from capability level 2 upward
  function automatic logic inv_cap_ok(input logic [1:0] cap);
    return cap >= 2'd2;
  endfunction

  // A slot is dropped by a tag invalidate when it is not global and tags agree
  function automatic logic tag_kill(input logic glob, input logic tag_eq);
    return !glob && tag_eq;
  endfunction

  // Probe qualification: valid, page matches, and tag matches or global
  function automatic logic probe_hit(input logic vld, input logic vpn_eq,
                                     input logic tag_eq, input logic glob);
    return vld && vpn_eq && (tag_eq || glob);
  endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ASID_W  = 8,
  parameter int VPN_W   = 19,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_glob,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic              wr_kill,
  input  logic              clr_tag_fire,
  input  logic              clr_all_fire,
  input  logic [ASID_W-1:0] cur_asid,
  output logic [VPN_W-1:0]  vpn_q  [ENTRIES],
  output logic [ASID_W-1:0] asid_q [ENTRIES],
  output logic [PFN_W-1:0]  pfn_q  [ENTRIES],
  output logic [ENTRIES-1:0] glob_vec,
  output logic [ENTRIES-1:0] valid_vec
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic sel;
    assign sel = wr_fire && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)                    valid_vec[i] <= 1'b0;
      else if (clr_all_fire)         valid_vec[i] <= 1'b0;
      else if (clr_tag_fire && tag_kill(glob_vec[i], asid_q[i] == cur_asid))
                                     valid_vec[i] <= 1'b0;
      else if (sel)                  valid_vec[i] <= !wr_kill;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        vpn_q[i]    <= wr_vpn;
        asid_q[i]   <= wr_asid;
        glob_vec[i] <= wr_glob;
        pfn_q[i]    <= wr_pfn;
      end
    end
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ASID_W  = 8,
  parameter int VPN_W   = 19,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [VPN_W-1:0]   key_vpn,
  input  logic [ASID_W-1:0]  key_asid,
  input  logic [VPN_W-1:0]   vpn_q  [ENTRIES],
  input  logic [ASID_W-1:0]  asid_q [ENTRIES],
  input  logic [ENTRIES-1:0] glob_vec,
  input  logic [ENTRIES-1:0] valid_vec,
  output logic               hit_any,
  output logic [IDX_W-1:0]   hit_idx
);
  logic [ENTRIES-1:0] hit_vec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = probe_hit(valid_vec[i], vpn_q[i] == key_vpn,
                                  asid_q[i] == key_asid, glob_vec[i]);
  end

  // Lowest index wins: scan downward so the last assignment is the smallest
  always_comb begin
    hit_any = |hit_vec;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ASID_W  = 8,
  parameter int VPN_W   = 19,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [4:0]        cmd_op,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic [1:0]        inv_cap,
  input  logic [VPN_W-1:0]  ent_vpn,
  input  logic [ASID_W-1:0] ent_asid,
  input  logic              ent_global,
  input  logic [PFN_W-1:0]  ent_pfn,
  input  logic              ent_kill,
  output logic              done,
  output logic              err,
  output logic [VPN_W-1:0]  rd_vpn,
  output logic [ASID_W-1:0] rd_asid,
  output logic              rd_global,
  output logic [PFN_W-1:0]  rd_pfn,
  output logic              rd_valid,
  output logic [IDX_W-1:0]  probe_idx,
  output logic              probe_miss
);
  logic is_rd, is_wr, is_ctag, is_call, is_probe, is_bad;
  logic rd_fire, wr_fire, probe_fire, bad_fire;
  logic inv_tag_fire, inv_all_fire, inv_blocked;
  logic cap_ok;

  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [ENTRIES-1:0] glob_vec, valid_vec;
  logic               hit_any;
  logic [IDX_W-1:0]   hit_idx;

  always_comb begin
    is_rd = 1'b0; is_wr = 1'b0; is_ctag = 1'b0;
    is_call = 1'b0; is_probe = 1'b0; is_bad = 1'b0;
    case (cmd_op)
      OP_READ:     is_rd    = 1'b1;
      OP_WRITE:    is_wr    = 1'b1;
      OP_INV_ASID: is_ctag  = 1'b1;
      OP_INV_ALL:  is_call  = 1'b1;
      OP_PROBE:    is_probe = 1'b1;
      default:     is_bad   = 1'b1;  // includes the random-write code
    endcase
  end

  assign cap_ok       = inv_cap_ok(inv_cap);
  assign rd_fire      = cmd_valid && is_rd;
  assign wr_fire      = cmd_valid && is_wr;
  assign probe_fire   = cmd_valid && is_probe;
  assign bad_fire     = cmd_valid && is_bad;
  assign inv_tag_fire = cmd_valid && is_ctag && cap_ok;
  assign inv_all_fire = cmd_valid && is_call && cap_ok;
  assign inv_blocked  = cmd_valid && (is_ctag || is_call) && !cap_ok;

  tlb_store #(.ENTRIES(ENTRIES), .ASID_W(ASID_W), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_fire      (wr_fire),
    .wr_idx       (cmd_idx),
    .wr_vpn       (ent_vpn),
    .wr_asid      (ent_asid),
    .wr_glob      (ent_global),
    .wr_pfn       (ent_pfn),
    .wr_kill      (ent_kill),
    .clr_tag_fire (inv_tag_fire),
    .clr_all_fire (inv_all_fire),
    .cur_asid     (cur_asid),
    .vpn_q        (vpn_q),
    .asid_q       (asid_q),
    .pfn_q        (pfn_q),
    .glob_vec     (glob_vec),
    .valid_vec    (valid_vec)
  );

  tlb_match #(.ENTRIES(ENTRIES), .ASID_W(ASID_W), .VPN_W(VPN_W)) u_match (
    .key_vpn   (ent_vpn),
    .key_asid  (cur_asid),
    .vpn_q     (vpn_q),
    .asid_q    (asid_q),
    .glob_vec  (glob_vec),
    .valid_vec (valid_vec),
    .hit_any   (hit_any),
    .hit_idx   (hit_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done       <= 1'b0;
      err        <= 1'b0;
      rd_vpn     <= '0;
      rd_asid    <= '0;
      rd_global  <= 1'b0;
      rd_pfn     <= '0;
      rd_valid   <= 1'b0;
      probe_idx  <= '0;
      probe_miss <= 1'b0;
    end else begin
      done <= cmd_valid;
      err  <= bad_fire;
      if (rd_fire) begin
        rd_vpn    <= vpn_q[cmd_idx];
        rd_asid   <= asid_q[cmd_idx];
        rd_global <= glob_vec[cmd_idx];
        rd_pfn    <= pfn_q[cmd_idx];
        rd_valid  <= valid_vec[cmd_idx];
      end
      if (probe_fire) begin
        probe_idx  <= hit_idx;
        probe_miss <= !hit_any;
      end
    end
  end
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
  parameter int ENTRIES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               done,
  input logic               err,
  input logic               inv_all_fire,
  input logic               inv_tag_fire,
  input logic               inv_blocked,
  input logic               bad_fire,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] glob_vec
);
  // R10
  done_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> done);
  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !done);
  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  // R9
  bad_op_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_fire |=> $stable(valid_vec));
  // R7
  inv_all_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all_fire |=> (valid_vec == '0));
  // R8
  inv_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_blocked |=> $stable(valid_vec));
  // R6
  glob_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_tag_fire |=> ((valid_vec & $past(glob_vec & valid_vec)) == $past(glob_vec & valid_vec)));
endmodule

bind asid_tlb tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .done         (done),
  .err          (err),
  .inv_all_fire (inv_all_fire),
  .inv_tag_fire (inv_tag_fire),
  .inv_blocked  (inv_blocked),
  .bad_fire     (bad_fire),
  .valid_vec    (valid_vec),
  .glob_vec     (glob_vec)
);

// File: tb/tb_asid_tlb.sv
module tb_asid_tlb;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [4:0]  cmd_op = '0;
  logic [3:0]  cmd_idx = '0;
  logic [7:0]  cur_asid = '0;
  logic [1:0]  inv_cap = '0;
  logic [18:0] ent_vpn = '0;
  logic [7:0]  ent_asid = '0;
  logic        ent_global = 1'b0;
  logic [19:0] ent_pfn = '0;
  logic        ent_kill = 1'b0;
  logic        done, err, rd_global, rd_valid, probe_miss;
  logic [18:0] rd_vpn;
  logic [7:0]  rd_asid;
  logic [19:0] rd_pfn;
  logic [3:0]  probe_idx;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [18:0] m_vpn [N];
  logic [7:0]  m_asid [N];
  logic        m_glob [N];
  logic [19:0] m_pfn [N];
  logic        m_val [N];

  always #2.5 clk = ~clk;

  asid_tlb dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Strobe for one cycle; on return the done cycle is being observed
  task automatic issue(input logic [4:0] op, input logic [3:0] idx);
    @(negedge clk);
    cmd_op = op; cmd_idx = idx; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic write_slot(input int i, input logic [18:0] v, input logic [7:0] a,
                            input logic g, input logic [19:0] p, input logic k);
    ent_vpn = v; ent_asid = a; ent_global = g; ent_pfn = p; ent_kill = k;
    issue(5'h02, 4'(i));
    chk(done && !err, "R2 write done", {62'd0, done, err}, 64'h2);
    m_vpn[i] = v; m_asid[i] = a; m_glob[i] = g; m_pfn[i] = p; m_val[i] = !k;
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < N; i++) begin
      issue(5'h01, 4'(i));
      chk(rd_valid == m_val[i], req, 64'(rd_valid), 64'(m_val[i]));
      chk({rd_vpn, rd_asid, rd_global, rd_pfn} == {m_vpn[i], m_asid[i], m_glob[i], m_pfn[i]},
          "R4 read fields", 64'({rd_vpn, rd_asid, rd_global, rd_pfn}),
          64'({m_vpn[i], m_asid[i], m_glob[i], m_pfn[i]}));
    end
  endtask

  task automatic probe_chk(input logic [18:0] v, input logic [7:0] a);
    int exp_idx;
    exp_idx = -1;
    for (int i = N - 1; i >= 0; i--)
      if (m_val[i] && m_vpn[i] == v && (m_asid[i] == a || m_glob[i])) exp_idx = i;
    ent_vpn = v; cur_asid = a;
    issue(5'h08, 4'd0);
    chk(probe_miss == (exp_idx < 0), "R5 probe miss", 64'(probe_miss), 64'(exp_idx < 0));
    if (exp_idx >= 0)
      chk(probe_idx == 4'(exp_idx), "R5 probe index", 64'(probe_idx), 64'(exp_idx));
  endtask

  task automatic fill();
    for (int i = 0; i < N; i++)
      write_slot(i, 19'h1000 + 19'((i * 3) % 7), 8'(i % 4), (i % 5) == 0,
                 20'hA0000 + 20'(i * 17), i == 7);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !err, "R1 reset outputs", {62'd0, done, err}, 64'd0);
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) begin
      issue(5'h01, 4'(i));
      chk(rd_valid == 1'b0, "R1 slot invalid after reset", 64'(rd_valid), 64'd0);
    end
    for (int i = 0; i < N; i++) m_val[i] = 1'b0;
    ent_vpn = 19'h1000; cur_asid = 8'd0;
    issue(5'h08, 4'd0);
    chk(probe_miss == 1'b1, "R1 probe misses after reset", 64'(probe_miss), 64'd1);

    // R2 R3 R4: fill table, slot 7 written with kill flag
    fill();
    read_all("R3 valid after write");
    // R10: done lasts one cycle
    @(negedge clk);
    chk(done == 1'b0, "R10 done single cycle", 64'(done), 64'd0);

    // R5 probe sweep across tags and page numbers
    for (int a = 0; a < 5; a++)
      for (int v = 0; v < 8; v++) probe_chk(19'h1000 + 19'(v), 8'(a));

    // R8: blocked invalidates for every tag and both low capability levels
    for (int c = 0; c < 2; c++) begin
      inv_cap = 2'(c);
      for (int a = 0; a < 4; a++) begin
        cur_asid = 8'(a);
        issue(5'h03, 4'd0);
        chk(done && !err, "R8 blocked tag invalidate done", {62'd0, done, err}, 64'h2);
      end
      issue(5'h04, 4'd0);
      chk(done && !err, "R8 blocked invalidate-all done", {62'd0, done, err}, 64'h2);
    end
    read_all("R8 state unchanged");

    // R6: tag invalidate with capability 2 and 3, sweeping tags
    for (int c = 2; c < 4; c++) begin
      fill();
      inv_cap = 2'(c);
      for (int a = 0; a < 4; a++) begin
        cur_asid = 8'(a);
        issue(5'h03, 4'd0);
        for (int i = 0; i < N; i++)
          if (m_asid[i] == 8'(a) && !m_glob[i]) m_val[i] = 1'b0;
        read_all("R6 tag invalidate");
        probe_chk(19'h1000, 8'(a));
      end
    end

    // R7: invalidate-all clears global slots too
    fill();
    inv_cap = 2'd2;
    issue(5'h04, 4'd0);
    for (int i = 0; i < N; i++) m_val[i] = 1'b0;
    read_all("R7 invalidate-all");

    // R9: every unsupported opcode
    fill();
    for (int op = 0; op < 32; op++) begin
      if (op == 1 || op == 2 || op == 3 || op == 4 || op == 8) continue;
      issue(5'(op), 4'd0);
      chk(done && err, "R9 unsupported opcode flagged", {62'd0, done, err}, 64'h3);
    end
    read_all("R9 state unchanged");
    issue(5'h01, 4'd0);
    chk(!err, "R9 err clears on valid opcode", 64'(err), 64'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule